// File: doc/BRIEF.md
# Transmit/Receive DMA Bus Arbiter

This block decides which of the two DMA engines of one channel, the transmit engine or the receive engine, owns the shared bus for the next transaction. Each engine raises a request line. The block answers with a registered one-hot grant. The owner keeps the grant for as long as it holds its request, and dropping the request ends the transaction.

A 5-bit configuration word selects the policy. Bit 0 chooses strict fixed priority (1) or weighted round-robin (0). Bit 1 names the favoured side: 0 favours receive and 1 favours transmit. In weighted mode, bits 4:2 hold a value v. Under continuous contention the favoured side then wins v+1 arbitrations for every one won by the other side. The configuration is treated as quasi-static and is sampled only when an arbitration takes place.

Top module: `txrx_dma_arbiter`

## Requirements
- R1: While `rst` is high on a clock edge, `grant` becomes 2'b00 and the favoured-win count returns to zero, so the first contended arbitration after reset goes to the favoured side.
- R2: `grant` is always 2'b00, 2'b01 (receive) or 2'b10 (transmit), and a side is granted only if its request was high at the edge that made the arbitration.
- R3: A granted side keeps its grant on every edge where its request is still high; on the first edge where its request is low, `grant` returns to 2'b00.
- R4: Arbitration happens only on an edge where `grant` is 2'b00, so `grant` never moves directly from one side to the other.
- R5: With `mode_cfg[0]`=1, the favoured side wins every contended arbitration whatever the value of `mode_cfg[4:2]`.
- R6: `mode_cfg[1]`=0 makes receive (grant 2'b01) the favoured side, and `mode_cfg[1]`=1 makes transmit (grant 2'b10) the favoured side.
- R7: With `mode_cfg[0]`=0 and `mode_cfg[4:2]`=v, back-to-back contended arbitrations repeat a cycle of v+1 favoured grants followed by one grant to the other side.
- R8: In weighted mode with v=0 (1:1), the first contended arbitration goes to the favoured side and the winners then alternate.
- R9: A lone requester is granted at the next arbitration edge whatever the count. A lone favoured grant leaves the count unchanged, and any grant to the non-favoured side clears it.
- R10: A change of `mode_cfg` while a grant is held does not disturb that grant and governs the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | 5 | [0] fixed(1)/weighted(0), [1] favoured side (1 = transmit), [4:2] weight value v |
| tx_req | input | 1 | Transmit DMA requests the bus |
| rx_req | input | 1 | Receive DMA requests the bus |
| grant | output | 2 | One-hot grant, bit 0 receive, bit 1 transmit |

## Verification
The embedded properties check on every cycle that the grant is one-hot, is given only to a requester, is held while the owner requests, is released when the owner stops, and never hops between sides. They also check that a lone requester is served at once and that fixed mode always picks the favoured side. The service ratio is a property of a whole sequence of arbitrations, so only the bench scenarios can show it. The same holds for the first winner after reset, for the rule that a lone favoured grant leaves the count alone, and for a mid-grant mode change taking effect at the next arbitration. The bench sweeps every combination of scheme, favoured side and weight value, and compares the winner order with a formula.

// File: rtl/txrx_arb_pkg.sv
package txrx_arb_pkg;
  localparam int MODE_W   = 5;
  localparam int WEIGHT_W = 3;
  localparam int GNT_W    = 2;

  localparam int BIT_FIXED   = 0;
  localparam int BIT_FAV_TX  = 1;
  localparam int WEIGHT_LSB  = 2;

  localparam logic [GNT_W-1:0] GNT_NONE = 2'b00;
  localparam logic [GNT_W-1:0] GNT_RX   = 2'b01;
  localparam logic [GNT_W-1:0] GNT_TX   = 2'b10;

  typedef struct packed {
    logic                fixed_prio;
    logic                fav_tx;
    logic [WEIGHT_W:0]   ratio;
  } arb_policy_t;
endpackage

// File: rtl/txrx_mode_decode.sv
module txrx_mode_decode
  import txrx_arb_pkg::*;
(
  input  logic [MODE_W-1:0] mode_cfg,
  output arb_policy_t       policy
);
  always_comb begin
    policy.fixed_prio = mode_cfg[BIT_FIXED];
    policy.fav_tx     = mode_cfg[BIT_FAV_TX];
    policy.ratio      = {1'b0, mode_cfg[WEIGHT_LSB +: WEIGHT_W]} + 1'b1;
  end
endmodule

// File: rtl/txrx_fav_counter.sv
module txrx_fav_counter
  import txrx_arb_pkg::*;
#(
  parameter int CNT_W = WEIGHT_W + 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             arb_fire,
  input  logic             win_fav,
  input  logic             contended,
  input  logic             fixed_prio,
  input  logic [WEIGHT_W:0] ratio,
  output logic [CNT_W-1:0] fav_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      fav_cnt <= '0;
    end else if (arb_fire) begin
      if (fixed_prio || !win_fav) begin
        fav_cnt <= '0;
      end else if (contended && fav_cnt != CNT_MAX) begin
        fav_cnt <= fav_cnt + 1'b1;
      end
    end
  end

  // R7: the count can never climb past the programmed ratio
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (!fixed_prio && arb_fire && contended) |-> (fav_cnt <= CNT_W'(ratio) || !win_fav));
endmodule

// File: rtl/txrx_grant_ctrl.sv
module txrx_grant_ctrl
  import txrx_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_req,
  input  logic             rx_req,
  input  logic [GNT_W-1:0] pick,
  output logic [GNT_W-1:0] grant_q,
  output logic             idle
);
  logic owner_req;

  assign idle      = (grant_q == GNT_NONE);
  assign owner_req = (grant_q[0] & rx_req) | (grant_q[1] & tx_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= GNT_NONE;
    end else if (idle) begin
      grant_q <= pick;
    end else if (!owner_req) begin
      grant_q <= GNT_NONE;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));
  p_rx_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    (idle && !rx_req) |=> !grant_q[0]);
  p_tx_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    (idle && !tx_req) |=> !grant_q[1]);
  p_hold_rx_r3: assert property (@(posedge clk) disable iff (rst)
    (grant_q[0] && rx_req) |=> grant_q[0]);
  p_hold_tx_r3: assert property (@(posedge clk) disable iff (rst)
    (grant_q[1] && tx_req) |=> grant_q[1]);
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (!idle && !owner_req) |=> (grant_q == GNT_NONE));
  p_no_hop_r4: assert property (@(posedge clk) disable iff (rst)
    !idle |=> (grant_q == GNT_NONE || grant_q == $past(grant_q)));
endmodule

// File: rtl/txrx_dma_arbiter.sv
module txrx_dma_arbiter
  import txrx_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_cfg,
  input  logic              tx_req,
  input  logic              rx_req,
  output logic [GNT_W-1:0]  grant
);
  localparam int CNT_W = WEIGHT_W + 1;

  arb_policy_t       policy;
  logic [CNT_W-1:0]  fav_cnt;
  logic              fav_req, oth_req, contended, quota_met, win_fav;
  logic [GNT_W-1:0]  fav_gnt, oth_gnt, pick;
  logic              idle;

  txrx_mode_decode u_decode (
    .mode_cfg (mode_cfg),
    .policy   (policy)
  );

  always_comb begin
    fav_gnt   = policy.fav_tx ? GNT_TX : GNT_RX;
    oth_gnt   = policy.fav_tx ? GNT_RX : GNT_TX;
    fav_req   = policy.fav_tx ? tx_req : rx_req;
    oth_req   = policy.fav_tx ? rx_req : tx_req;
    contended = fav_req && oth_req;
    quota_met = (fav_cnt >= CNT_W'(policy.ratio));
    if (policy.fixed_prio) win_fav = fav_req;
    else                   win_fav = fav_req && !(oth_req && quota_met);
    if (win_fav)      pick = fav_gnt;
    else if (oth_req) pick = oth_gnt;
    else              pick = GNT_NONE;
  end

  txrx_fav_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .arb_fire   (idle && (tx_req || rx_req)),
    .win_fav    (win_fav),
    .contended  (contended),
    .fixed_prio (policy.fixed_prio),
    .ratio      (policy.ratio),
    .fav_cnt    (fav_cnt)
  );

  txrx_grant_ctrl u_grant (
    .clk     (clk),
    .rst     (rst),
    .tx_req  (tx_req),
    .rx_req  (rx_req),
    .pick    (pick),
    .grant_q (grant),
    .idle    (idle)
  );

  // R5: fixed scheme hands a contended arbitration to the favoured side
  p_fixed_fav_r5: assert property (@(posedge clk) disable iff (rst)
    (idle && contended && policy.fixed_prio) |=> (grant == $past(fav_gnt)));
  // R9: a lone requester is served at the very next edge
  p_lone_rx_r9: assert property (@(posedge clk) disable iff (rst)
    (idle && rx_req && !tx_req) |=> (grant == GNT_RX));
  p_lone_tx_r9: assert property (@(posedge clk) disable iff (rst)
    (idle && tx_req && !rx_req) |=> (grant == GNT_TX));
endmodule

// File: tb/txrx_dma_arbiter_tb.sv
module txrx_dma_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] mode_cfg = 5'd0;
  logic       tx_req = 1'b0;
  logic       rx_req = 1'b0;
  logic [1:0] grant;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  txrx_dma_arbiter u_dut (
    .clk(clk), .rst(rst), .mode_cfg(mode_cfg),
    .tx_req(tx_req), .rx_req(rx_req), .grant(grant)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tx_req = 0; rx_req = 0;
    step(); step();
    rst = 1'b0;
  endtask

  // one arbitration with the given requests, then release; returns winner
  task automatic round(input logic want_rx, input logic want_tx, output logic [1:0] won);
    rx_req = want_rx; tx_req = want_tx;
    step();
    won = grant;
    rx_req = 0; tx_req = 0;
    step();
    check("R3 release", grant, 2'b00);
  endtask

  initial begin
    logic [1:0] w, fav, oth, exp;
    @(negedge clk);
    do_reset();
    check("R1 reset idle", grant, 2'b00);

    // R5 R6 R7 R8: full sweep of scheme, favoured side and weight value
    for (int fx = 0; fx < 2; fx++)
      for (int fv = 0; fv < 2; fv++)
        for (int v = 0; v < 8; v++) begin
          mode_cfg = {3'(v), 1'(fv), 1'(fx)};
          do_reset();
          fav = fv ? 2'b10 : 2'b01;
          oth = fv ? 2'b01 : 2'b10;
          for (int n = 0; n < 20; n++) begin
            round(1, 1, w);
            if (fx == 1) exp = fav;
            else exp = ((n % (v + 2)) == v + 1) ? oth : fav;
            if (fx == 1) check("R5 fixed favoured wins", w, exp);
            else if (v == 0) check("R8 one-to-one alternation", w, exp);
            else check("R7 weighted ratio", w, exp);
            if (n == 0) check("R6 favoured side first after R1 reset", w, fav);
          end
        end

    // R9: lone favoured grant does not advance the count (2:1, favour rx)
    mode_cfg = 5'b001_0_0;
    do_reset();
    round(1, 1, w); check("R9 contended fav", w, 2'b01);
    round(1, 0, w); check("R9 lone fav", w, 2'b01);
    round(1, 1, w); check("R9 count unchanged, fav again", w, 2'b01);
    round(1, 1, w); check("R9 quota reached, other", w, 2'b10);
    // lone other grant whatever the count, and it clears the count
    round(1, 1, w); check("R9 fav after other", w, 2'b01);
    round(0, 1, w); check("R9 lone other served", w, 2'b10);
    round(1, 1, w); check("R9 count cleared", w, 2'b01);
    round(1, 1, w); check("R9 count cleared second", w, 2'b01);
    round(0, 0, w); check("R2 no request no grant", w, 2'b00);

    // R3 R4: hold while owner requests, other side waits
    mode_cfg = 5'b000_1_0;
    do_reset();
    tx_req = 1; step();
    check("R2 tx granted", grant, 2'b10);
    rx_req = 1;
    for (int k = 0; k < 5; k++) begin step(); check("R3 hold tx", grant, 2'b10); end
    tx_req = 0; step();
    check("R4 no hop to rx", grant, 2'b00);
    step();
    check("R4 rx after idle", grant, 2'b01);
    rx_req = 0; step();
    check("R3 rx release", grant, 2'b00);

    // R10: mode change while held applies at next arbitration
    mode_cfg = 5'b000_0_1;
    do_reset();
    tx_req = 1; step();
    check("R10 tx granted under rx-fixed", grant, 2'b10);
    rx_req = 1;
    mode_cfg = 5'b000_1_1;
    step(); check("R10 grant undisturbed", grant, 2'b10);
    tx_req = 0; rx_req = 0; step();
    round(1, 1, w); check("R10 new favoured side applies", w, 2'b10);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule